// File: doc/BRIEF.md
# TX/RX Bit Stream Mode Switcher

This block connects a pair of bit buffers to the bit clock and serial data lines of a radio transceiver. The transceiver supplies a free-running bit clock. While the block is in transmit mode it presents the next transmit bit on every falling clock level change, because the transceiver samples on the rising edge. While it is in receive mode, and not in duplex operation, it captures the receive line on every rising change and hands that bit out with a one-cycle valid flag.

Moving between the two modes needs a load-enable strobe, which makes the transceiver commit its previously written frequency and mode word. The strobe has to land at a particular point in the symbol stream. On entry to transmit, the strobe follows the first bit driven. On the way back to receive, it fires only on an even-phase bit, and only after a programmable delay of a quarter bit time. An even/odd phase flag toggles with every transmitted bit and is set again at each switch. A bit clock change that arrives while a strobe sequence is running is held off and is handled when the sequence ends.

Top module: `bitstream_mode_switcher`

## Requirements
- R1: After reset, tx_mode, strobe, tx_pop, tx_data and rx_valid are all 0, so the block starts in receive mode.
- R2: On a falling change of the synchronised bit clock in transmit mode with tx_ready high, tx_data takes tx_bit and tx_pop pulses for one cycle. With tx_ready low, tx_data becomes 0 and there is no pop, but the phase flag still toggles.
- R3: On a rising change in receive mode with duplex low, rx_bit takes rx_data_in and rx_valid pulses for one cycle. Rising changes give no rx_valid in transmit mode or when duplex is high.
- R4: Only a change of level counts. A level held for any time causes one event at most, and a level that repeats is ignored. Bit clock input passes through a two-flop synchroniser, so tx_pop, tx_data, rx_valid and a transmit-entry strobe change on the third clock edge after bclk_in changes (cycle index 2, counting from the first edge).
- R5: A to_tx_req pulse in receive mode sets tx_mode on the next cycle and arms an entry request. On the next falling change, the first bit is driven and strobe goes high in that same cycle for STB_CYC cycles. The request then clears and the phase is set to even.
- R6: A to_rx_req pulse in transmit mode arms an exit request. The phase is even on the first bit after entry and alternates after that. The exit fires only on a falling change whose new phase is even, so it lands on bits 3, 5, 7 and so on. Its strobe rises DLY_CYC cycles after that bit is driven and lasts STB_CYC cycles.
- R7: When the exit strobe ends, tx_mode drops in the cycle after its last high cycle, and the phase is set to odd. Later falling changes pop nothing and leave tx_data unchanged.
- R8: A bit clock change that arrives during the exit delay or a strobe is held until the sequence ends, and is then handled in the new mode. A rising change during an exit gives rx_valid one cycle after tx_mode falls.
- R9: A to_rx_req in receive mode and a to_tx_req in transmit mode are both ignored. Neither leaves a pending request that could fire a strobe later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Asynchronous transceiver bit clock |
| duplex | input | 1 | Duplex operation; suppresses receive sampling |
| tx_bit | input | 1 | Next bit from the transmit buffer |
| tx_ready | input | 1 | Transmit buffer holds a bit |
| tx_pop | output | 1 | One-cycle pulse: tx_bit was consumed |
| tx_data | output | 1 | Transmit data line to the transceiver |
| rx_data_in | input | 1 | Receive data line from the transceiver |
| rx_bit | output | 1 | Last sampled receive bit |
| rx_valid | output | 1 | One-cycle pulse: rx_bit is new |
| to_tx_req | input | 1 | Request a switch to transmit |
| to_rx_req | input | 1 | Request a switch to receive |
| tx_mode | output | 1 | 1 in transmit mode, 0 in receive mode |
| strobe | output | 1 | Load-enable strobe to the transceiver |

## Verification
If the phase flag drifts by one bit, the exit strobe lands one bit time early or late. That shows up on the first falling change after to_rx_req, as a strobe where none is expected or a missing one. A stale pending request shows up as an extra strobe on a later bit in the wrong mode. A lost or repeated bit clock event shows up as a missing or doubled tx_pop or rx_valid within the same half bit period. A fault in the hold-off logic shows as rx_valid arriving before tx_mode drops, or never arriving.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_DELAY  = 2'd1,
        SEQ_STROBE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic last_lvl;
        logic tx_mode;
        logic tx_pend;
        logic rx_pend;
        logic phase;
        logic tx_data;
        logic tx_pop;
        logic rx_bit;
        logic rx_valid;
    } ctl_state_t;

endpackage

// File: rtl/bsw_bit_sync.sv
module bsw_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end else begin : g_single
            always_comb sh_d = d;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bsw_strobe_seq.sv
module bsw_strobe_seq
    import bsw_pkg::*;
#(
    parameter int DLY_CYC = 26,
    parameter int STB_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_tx,
    input  logic start_rx,
    output logic busy,
    output logic strobe,
    output logic done_rx
);
    localparam int MAXV  = (DLY_CYC > STB_CYC) ? DLY_CYC : STB_CYC;
    localparam int CNT_W = $clog2(MAXV + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             kind_rx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        done_rx = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (start_tx) begin
                    seq_d.state   = SEQ_STROBE;
                    seq_d.cnt     = CNT_W'(STB_CYC - 1);
                    seq_d.kind_rx = 1'b0;
                end else if (start_rx) begin
                    seq_d.state   = SEQ_DELAY;
                    seq_d.cnt     = CNT_W'(DLY_CYC - 1);
                    seq_d.kind_rx = 1'b1;
                end
            end
            SEQ_DELAY: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_STROBE;
                    seq_d.cnt   = CNT_W'(STB_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SEQ_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_IDLE;
                    done_rx     = seq_q.kind_rx;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: SEQ_IDLE, cnt: '0, kind_rx: 1'b0};
        else        seq_q <= seq_d;
    end

    assign busy   = (seq_q.state != SEQ_IDLE);
    assign strobe = (seq_q.state == SEQ_STROBE);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_tx || start_rx) |-> !busy); // R8

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_tx, start_rx})); // R6
endmodule

// File: rtl/bitstream_mode_switcher.sv
module bitstream_mode_switcher
    import bsw_pkg::*;
#(
    parameter int   DLY_CYC     = 26,
    parameter int   STB_CYC     = 2,
    parameter int   SYNC_STAGES = 2,
    parameter logic EVEN_PHASE  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic duplex,
    input  logic tx_bit,
    input  logic tx_ready,
    output logic tx_pop,
    output logic tx_data,
    input  logic rx_data_in,
    output logic rx_bit,
    output logic rx_valid,
    input  logic to_tx_req,
    input  logic to_rx_req,
    output logic tx_mode,
    output logic strobe
);
    ctl_state_t ctl_d, ctl_q;
    logic bclk_s, busy, done_rx, start_tx, start_rx, edge_ev, nphase;

    bsw_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bclk_in), .q(bclk_s)
    );

    bsw_strobe_seq #(.DLY_CYC(DLY_CYC), .STB_CYC(STB_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
        .busy(busy), .strobe(strobe), .done_rx(done_rx)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.tx_pop   = 1'b0;
        ctl_d.rx_valid = 1'b0;
        start_tx       = 1'b0;
        start_rx       = 1'b0;
        nphase         = ctl_q.phase;

        if (done_rx) begin
            ctl_d.tx_mode = 1'b0;
            ctl_d.rx_pend = 1'b0;
            ctl_d.phase   = ~EVEN_PHASE;
        end else begin
            if (to_tx_req && !ctl_q.tx_mode) begin
                ctl_d.tx_mode = 1'b1;
                ctl_d.tx_pend = 1'b1;
            end
            if (to_rx_req && ctl_q.tx_mode) begin
                ctl_d.rx_pend = 1'b1;
            end
        end

        edge_ev = (bclk_s != ctl_q.last_lvl) && !busy;
        if (edge_ev) begin
            ctl_d.last_lvl = bclk_s;
            if (!bclk_s && ctl_q.tx_mode) begin
                ctl_d.tx_data = tx_ready & tx_bit;
                ctl_d.tx_pop  = tx_ready;
                nphase        = ~ctl_q.phase;
                if (ctl_q.tx_pend) begin
                    start_tx      = 1'b1;
                    ctl_d.tx_pend = 1'b0;
                    nphase        = EVEN_PHASE;
                end else if (ctl_q.rx_pend && (nphase == EVEN_PHASE)) begin
                    start_rx = 1'b1;
                end
                ctl_d.phase = nphase;
            end
            if (bclk_s && !ctl_q.tx_mode && !duplex) begin
                ctl_d.rx_bit   = rx_data_in;
                ctl_d.rx_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.phase    <= ~EVEN_PHASE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_pop   = ctl_q.tx_pop;
    assign tx_data  = ctl_q.tx_data;
    assign rx_bit   = ctl_q.rx_bit;
    assign rx_valid = ctl_q.rx_valid;
    assign tx_mode  = ctl_q.tx_mode;

    AST_POP_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> $past(tx_mode)); // R2

    AST_NO_RX_IN_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(duplex)); // R3

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!tx_pop && !rx_valid)); // R8

    AST_TX_END_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_mode) |-> $past(strobe)); // R7

    AST_STROBE_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> tx_mode); // R5
endmodule

// File: tb/bitstream_mode_switcher_tb.sv
module bitstream_mode_switcher_tb;
    localparam int DLY  = 10;
    localparam int STB  = 3;
    localparam int HALF = 24;

    logic clk = 0, rst_n = 0, bclk_in = 0, duplex = 0;
    logic tx_bit = 0, tx_ready = 0, rx_data_in = 0;
    logic to_tx_req = 0, to_rx_req = 0;
    logic tx_pop, tx_data, rx_bit, rx_valid, tx_mode, strobe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic src_q[$], exp_tx[$], exp_rx[$];

    int stb_first, stb_len, pop_first, pops, rxv, rxv_first, txm_fall;

    always #5 clk = ~clk;

    bitstream_mode_switcher #(.DLY_CYC(DLY), .STB_CYC(STB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .duplex(duplex),
        .tx_bit(tx_bit), .tx_ready(tx_ready), .tx_pop(tx_pop), .tx_data(tx_data),
        .rx_data_in(rx_data_in), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .to_tx_req(to_tx_req), .to_rx_req(to_rx_req), .tx_mode(tx_mode), .strobe(strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic refresh_src();
        tx_ready = (src_q.size() != 0);
        tx_bit   = (src_q.size() != 0) ? src_q[0] : 1'b0;
    endtask

    task automatic push_tx(input logic b);
        src_q.push_back(b);
        exp_tx.push_back(b);
        refresh_src();
    endtask

    // monitor: scoreboard compare
    always begin
        @(posedge clk); #1;
        if (rst_n && tx_pop) begin
            chk(exp_tx.size() != 0, "R2 pop with no expected bit", 1, 0);
            if (exp_tx.size() != 0) begin
                logic e;
                e = exp_tx.pop_front();
                chk(tx_data == e, "R2 tx_data", int'(tx_data), int'(e));
            end
            if (src_q.size() != 0) void'(src_q.pop_front());
            refresh_src();
        end
        if (rst_n && rx_valid) begin
            chk(exp_rx.size() != 0, "R3 rx_valid with no expected bit", 1, 0);
            if (exp_rx.size() != 0) begin
                logic e;
                e = exp_rx.pop_front();
                chk(rx_bit == e, "R3 rx_bit", int'(rx_bit), int'(e));
            end
        end
    end

    task automatic half(input logic lvl, input int n, input int flip_at);
        logic prev_txm;
        @(negedge clk);
        bclk_in = lvl;
        stb_first = -1; stb_len = 0; pop_first = -1; pops = 0;
        rxv = 0; rxv_first = -1; txm_fall = -1; prev_txm = tx_mode;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (strobe) begin
                if (stb_first < 0) stb_first = i;
                stb_len++;
            end
            if (tx_pop) begin
                pops++;
                if (pop_first < 0) pop_first = i;
            end
            if (rx_valid) begin
                rxv++;
                if (rxv_first < 0) rxv_first = i;
            end
            if (prev_txm && !tx_mode && txm_fall < 0) txm_fall = i;
            prev_txm = tx_mode;
            if (i == flip_at) begin
                @(negedge clk);
                bclk_in = ~lvl;
            end
        end
    endtask

    task automatic pulse_tx();
        @(negedge clk); to_tx_req = 1;
        @(negedge clk); to_tx_req = 0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); to_rx_req = 1;
        @(negedge clk); to_rx_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        refresh_src();
        repeat (3) @(posedge clk);
        #1;
        chk(tx_mode == 0 && strobe == 0 && tx_pop == 0 && tx_data == 0 && rx_valid == 0,
            "R1 reset outputs", int'({tx_mode, strobe, tx_pop, tx_data, rx_valid}), 0);
        @(negedge clk); rst_n = 1;
        repeat (4) @(posedge clk);

        // receive mode sampling
        rx_data_in = 1; exp_rx.push_back(1);
        half(1, HALF, -1);
        chk(rxv == 1, "R3 rx sample on rising", rxv, 1);
        chk(rxv_first == 2, "R4 rx latency", rxv_first, 2);
        half(1, HALF, -1);
        chk(rxv == 0, "R4 repeated level ignored", rxv, 0);
        half(0, HALF, -1);
        chk(pops == 0 && stb_first < 0, "R3 falling in rx does nothing", pops, 0);
        rx_data_in = 0; exp_rx.push_back(0);
        half(1, HALF, -1);
        chk(rxv == 1, "R3 second rx sample", rxv, 1);
        half(0, HALF, -1);

        // duplex suppresses sampling
        duplex = 1; rx_data_in = 1;
        half(1, HALF, -1);
        chk(rxv == 0, "R3 duplex suppresses rx", rxv, 0);
        half(0, HALF, -1);
        duplex = 0;

        // exit request in receive mode must be ignored
        pulse_rx();

        // enter transmit
        push_tx(1); push_tx(0); push_tx(1); push_tx(1); push_tx(0); push_tx(1);
        pulse_tx();
        #1;
        chk(tx_mode == 1, "R5 tx_mode after to_tx_req", int'(tx_mode), 1);
        half(1, HALF, -1);
        chk(rxv == 0, "R3 no rx sample in tx mode", rxv, 0);
        half(0, HALF, -1);
        chk(stb_first == 2, "R5 entry strobe start", stb_first, 2);
        chk(stb_len == STB, "R5 entry strobe width", stb_len, STB);
        chk(pop_first == 2 && pops == 1, "R4 tx latency", pop_first, 2);
        half(1, HALF, -1);
        half(0, HALF, -1);
        chk(stb_first < 0 && pops == 1, "R9 no strobe on bit 2", stb_first, -1);
        half(1, HALF, -1);
        half(0, HALF, -1);
        chk(stb_first < 0, "R9 stale exit request not kept (bit 3)", stb_first, -1);
        pulse_tx();
        pulse_rx();
        half(1, HALF, -1);
        half(0, HALF, -1);
        chk(stb_first < 0 && pops == 1, "R6 no exit on odd phase; R9 no re-entry strobe", stb_first, -1);
        half(1, HALF, -1);
        half(0, HALF, -1);
        chk(stb_first == 2 + DLY, "R6 exit strobe delay", stb_first, 2 + DLY);
        chk(stb_len == STB, "R6 exit strobe width", stb_len, STB);
        chk(txm_fall == 2 + DLY + STB, "R7 tx_mode drop timing", txm_fall, 2 + DLY + STB);

        // back in receive
        rx_data_in = 0; exp_rx.push_back(0);
        half(1, HALF, -1);
        chk(rxv == 1, "R7 rx resumes after exit", rxv, 1);
        half(0, HALF, -1);
        chk(pops == 0 && tx_data == 0, "R7 no pop after exit", pops, 0);

        // re-enter, empty buffer, then hold-off on exit
        pulse_tx();
        half(1, HALF, -1);
        half(0, HALF, -1);
        chk(pops == 1 && stb_first == 2, "R5 second entry", pops, 1);
        half(1, HALF, -1);
        half(0, HALF, -1);
        chk(pops == 0 && tx_data == 0, "R2 empty buffer drives 0", int'(tx_data), 0);
        half(1, HALF, -1);
        pulse_rx();
        rx_data_in = 1; exp_rx.push_back(1);
        half(0, 40, 4);
        chk(stb_first == 2 + DLY, "R6 exit on bit 3 after empty bit", stb_first, 2 + DLY);
        chk(rxv == 1 && rxv_first == 3 + DLY + STB, "R8 held edge after exit", rxv_first, 3 + DLY + STB);

        repeat (5) @(posedge clk);
        #1;
        chk(exp_tx.size() == 0, "R2 all tx bits popped", exp_tx.size(), 0);
        chk(exp_rx.size() == 0, "R3 all rx bits seen", exp_rx.size(), 0);
        finish_run();
    end
endmodule